// File: doc/BRIEF.md
# Radio Power-Mode Controller

This block decides which analog blocks of a low-power wireless transmitter are powered at any moment. It enables the low-power regulator, the wake-up timer, the low-battery detector, the temperature sensor, the crystal oscillator and the PLL. A power-down pin, a software-reset strobe and a mode register written over a small register bus drive these choices. The current mode is reported on its own output.

Five idle sub-modes are decoded from the mode register, with a fixed priority when several control bits are set. Raising the power-down pin drops the block into a powered-off state that erases its registers. Lowering the pin starts a timed reset sequence. Register access is refused while powered off and during the reset sequence.

The block collects interrupt events into a pending register. Reading that register clears it. The three lowest-current sub-modes cannot be entered while an interrupt is pending. They also cannot be entered after a power-on reset until the first status read. While entry is blocked, the block parks in READY with the crystal running.

Top module: `radio_pwr_ctrl`

## Requirements
- R1: While `sdn_i` is high, the mode becomes OFF (code 0) at the next rising edge. All enables are then 0, `bus_ok_o` is 0, reads return 0, and the mode and pending registers are cleared.
- R2: A falling `sdn_i` (or release of `rst_n`) starts a reset sequence. During it the mode is RESET (code 1) for `POR_CYCLES` cycles, only `ldo_en_o` is set, writes are ignored and reads return 0.
- R3: Mode register bit layout: bit0 crystal-on, bit1 PLL-on, bit4 temperature-sensor, bit5 low-battery-detect, bit6 wake-up timer. Bits 7, 3 and 2 are not stored and read as 0. The mode register sits at address 0x07 and the interrupt status register at address 0x04.
- R4: After the reset sequence, the mode register reads 0x01 and the mode is READY (code 5).
- R5: A mode register value of 0x00 selects STANDBY (code 2), in which only `ldo_en_o` is set.
- R6: Bit6 alone selects SLEEP (code 3), in which the regulator and the wake-up timer are enabled.
- R7: Bit5 and/or bit4 select SENSOR (code 4). SENSOR enables the regulator and the wake-up timer, plus each sensor whose bit is set.
- R8: Bit0 selects READY. READY enables the regulator and the crystal. The wake-up timer and the sensors follow their own bits.
- R9: Bit1 selects TUNE (code 6), which enables the regulator, the crystal and the PLL whatever bit0 holds.
- R10: When several bits are set, the selected mode follows the priority TUNE > READY > SENSOR > SLEEP > STANDBY.
- R11: An `irq_evt_i` bit sets the matching pending bit, and `irq_n_o` is low while any bit is pending. A read of address 0x04 returns the pending bits and clears them. An event arriving in the same cycle as that read stays pending.
- R12: While a bit is pending, or after a power-on reset before the first status read, a STANDBY, SLEEP or SENSOR selection is held as READY.
- R13: A `swrst_i` pulse in an idle mode restarts the reset sequence. It restores the mode register to 0x01 and clears the pending bits, but does not re-arm the post-power-on read requirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous supply-connect reset, active low |
| sdn_i | input | 1 | Power-down pin, high = OFF |
| swrst_i | input | 1 | Software reset strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, 0 when not reading or refused |
| irq_evt_i | input | IRQW | Interrupt event pulses |
| irq_n_o | output | 1 | Low while any interrupt is pending |
| bus_ok_o | output | 1 | High when register access is accepted |
| mode_o | output | 3 | Current mode code |
| ldo_en_o | output | 1 | Low-power regulator enable |
| wut_en_o | output | 1 | Wake-up timer enable |
| lbd_en_o | output | 1 | Low-battery detector enable |
| ts_en_o | output | 1 | Temperature sensor enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| pll_en_o | output | 1 | PLL enable |

## Verification
A write to the mode register becomes visible in the register and in the bit-following enables one edge after the strobe is sampled. The mode code moves one edge after that. A status read clears the pending bits at the sampling edge, so a blocked low-power mode is entered one edge later. The reset sequence lasts exactly `POR_CYCLES` edges after the edge that leaves OFF. The bench applies each stimulus just after a falling edge and advances a behavioural model at the next rising edge. It compares every output, including the combinational read data, before the following rising edge, so each result is checked in the cycle it is due.

// File: rtl/radio_pwr_ctrl.sv
module radio_pwr_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int IRQW = 4,
  parameter int POR_CYCLES = 8,
  parameter logic [AW-1:0] MODE_ADDR = AW'(7),
  parameter logic [AW-1:0] IRQ_ADDR = AW'(4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sdn_i,
  input  logic          swrst_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [IRQW-1:0] irq_evt_i,
  output logic          irq_n_o,
  output logic          bus_ok_o,
  output logic [2:0]    mode_o,
  output logic          ldo_en_o,
  output logic          wut_en_o,
  output logic          lbd_en_o,
  output logic          ts_en_o,
  output logic          xtal_en_o,
  output logic          pll_en_o
);
  localparam int CW = $clog2(POR_CYCLES) + 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(POR_CYCLES - 1);
  localparam int B_XTAL = 0, B_PLL = 1, B_TS = 4, B_LBD = 5, B_WUT = 6;
  localparam logic [DW-1:0] CTRL_MASK = DW'(8'h73);
  localparam logic [DW-1:0] CTRL_DEF = DW'(8'h01);

  typedef enum logic [2:0] {
    M_OFF = 3'd0, M_RST = 3'd1, M_STBY = 3'd2, M_SLEEP = 3'd3,
    M_SENSE = 3'd4, M_READY = 3'd5, M_TUNE = 3'd6
  } mode_t;

  mode_t           mode_q, target;
  logic [CW-1:0]   cnt_q;
  logic [DW-1:0]   ctrl_q, pend_ext;
  logic [IRQW-1:0] pend_q;
  logic            por_q;
  logic            idle, blocked, wr_ctrl, rd_ctrl, rd_irq;

  assign idle    = (mode_q != M_OFF) && (mode_q != M_RST);
  assign blocked = por_q || (|pend_q);
  assign wr_ctrl = idle && bus_wr_i && (bus_addr_i == MODE_ADDR);
  assign rd_ctrl = idle && bus_rd_i && (bus_addr_i == MODE_ADDR);
  assign rd_irq  = idle && bus_rd_i && (bus_addr_i == IRQ_ADDR);

  always_comb begin
    if (ctrl_q[B_PLL])                        target = M_TUNE;
    else if (ctrl_q[B_XTAL])                  target = M_READY;
    else if (ctrl_q[B_LBD] || ctrl_q[B_TS])   target = M_SENSE;
    else if (ctrl_q[B_WUT])                   target = M_SLEEP;
    else                                      target = M_STBY;
    if (blocked && (target < M_READY))        target = M_READY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_RST;
      cnt_q  <= CNT_LOAD;
      ctrl_q <= CTRL_DEF;
      pend_q <= '0;
      por_q  <= 1'b1;
    end else if (sdn_i) begin
      mode_q <= M_OFF;
      cnt_q  <= '0;
      ctrl_q <= '0;
      pend_q <= '0;
      por_q  <= 1'b0;
    end else if (mode_q == M_OFF) begin
      mode_q <= M_RST;
      cnt_q  <= CNT_LOAD;
      ctrl_q <= CTRL_DEF;
      por_q  <= 1'b1;
    end else if (mode_q == M_RST) begin
      if (cnt_q == '0) mode_q <= target;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (swrst_i) begin
      mode_q <= M_RST;
      cnt_q  <= CNT_LOAD;
      ctrl_q <= CTRL_DEF;
      pend_q <= '0;
    end else begin
      mode_q <= target;
      if (wr_ctrl) ctrl_q <= bus_wdata_i & CTRL_MASK;
      if (rd_irq) por_q <= 1'b0;
      pend_q <= (rd_irq ? '0 : pend_q) | irq_evt_i;
    end
  end

  always_comb begin
    pend_ext = '0;
    pend_ext[IRQW-1:0] = pend_q;
  end

  assign bus_rdata_o = rd_ctrl ? ctrl_q : (rd_irq ? pend_ext : '0);
  assign bus_ok_o    = idle;
  assign irq_n_o     = ~|pend_q;
  assign mode_o      = mode_q;

  always_comb begin
    ldo_en_o = 1'b0; wut_en_o = 1'b0; lbd_en_o = 1'b0;
    ts_en_o  = 1'b0; xtal_en_o = 1'b0; pll_en_o = 1'b0;
    case (mode_q)
      M_RST, M_STBY: ldo_en_o = 1'b1;
      M_SLEEP: begin ldo_en_o = 1'b1; wut_en_o = 1'b1; end
      M_SENSE: begin
        ldo_en_o = 1'b1; wut_en_o = 1'b1;
        lbd_en_o = ctrl_q[B_LBD]; ts_en_o = ctrl_q[B_TS];
      end
      M_READY, M_TUNE: begin
        ldo_en_o = 1'b1; xtal_en_o = 1'b1;
        pll_en_o = (mode_q == M_TUNE);
        wut_en_o = ctrl_q[B_WUT]; lbd_en_o = ctrl_q[B_LBD]; ts_en_o = ctrl_q[B_TS];
      end
      default: ;
    endcase
  end

  assert_off_on_sdn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sdn_i |=> (mode_o == 3'd0) && !bus_ok_o && irq_n_o);

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |-> !(ldo_en_o || wut_en_o || lbd_en_o || ts_en_o || xtal_en_o || pll_en_o)
                          && (bus_rdata_o == '0));

  assert_reset_holds_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RST && cnt_q != '0 && !sdn_i) |=> $stable(ctrl_q) && (mode_o == 3'd1));

  assert_pll_needs_xtal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en_o |-> xtal_en_o && ldo_en_o);

  assert_read_clears_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_irq && !swrst_i && !sdn_i && irq_evt_i == '0) |=> irq_n_o);

  assert_lowpower_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && blocked && !sdn_i) |=> (mode_o >= 3'd5 || mode_o == 3'd1));
endmodule

// File: tb/radio_pwr_ctrl_test.sv
module radio_pwr_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int POR = 8;

  logic clk = 1'b0, rst_n = 1'b0, sdn = 1'b0, swrst = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [3:0] evt = '0;
  logic irq_n, ok;
  logic [2:0] mode;
  logic ldo, wut, lbd, ts, xtal, pll;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_pwr_ctrl #(.POR_CYCLES(POR)) uut (
    .clk(clk), .rst_n(rst_n), .sdn_i(sdn), .swrst_i(swrst), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_evt_i(evt),
    .irq_n_o(irq_n), .bus_ok_o(ok), .mode_o(mode), .ldo_en_o(ldo), .wut_en_o(wut),
    .lbd_en_o(lbd), .ts_en_o(ts), .xtal_en_o(xtal), .pll_en_o(pll));

  int checks = 0, fails = 0;
  string tag = "R4";
  int m_mode, m_cnt, m_ctrl, m_pend, m_por;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int pick(int c, int p, int por);
    int t;
    if (c & 'h02) t = 6;
    else if (c & 'h01) t = 5;
    else if (c & 'h30) t = 4;
    else if (c & 'h40) t = 3;
    else t = 2;
    if ((p != 0 || por != 0) && t < 5) t = 5;
    return t;
  endfunction

  function automatic int en_of(int md, int c);
    int w = (c >> 6) & 1, l = (c >> 5) & 1, s = (c >> 4) & 1;
    case (md)
      1, 2: return 1;
      3: return 3;
      4: return 3 | (l << 2) | (s << 3);
      5: return 1 | (w << 1) | (l << 2) | (s << 3) | 16;
      6: return 1 | (w << 1) | (l << 2) | (s << 3) | 48;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 1; m_cnt = POR - 1; m_ctrl = 1; m_pend = 0; m_por = 1;
  endtask

  task automatic step(logic r, logic s, logic sw, logic w, logic rr, int a, int d, int e);
    int exp_rd, t;
    rst_n = r; sdn = s; swrst = sw; wr = w; rd = rr; addr = 8'(a); wdata = 8'(d); evt = 4'(e);
    if (!r) model_reset();
    #1;
    exp_rd = 0;
    if (m_mode >= 2 && rr) exp_rd = (a == 7) ? m_ctrl : ((a == 4) ? m_pend : 0);
    chk("mode", mode, m_mode);
    chk("enables", {pll, xtal, ts, lbd, wut, ldo}, en_of(m_mode, m_ctrl));
    chk("bus_ok", ok, (m_mode >= 2) ? 1 : 0);
    chk("irq_n", irq_n, (m_pend == 0) ? 1 : 0);
    chk("rdata", rdata, exp_rd);
    @(posedge clk);
    if (r) begin
      if (s) begin m_mode = 0; m_cnt = 0; m_ctrl = 0; m_pend = 0; m_por = 0; end
      else if (m_mode == 0) begin m_mode = 1; m_cnt = POR - 1; m_ctrl = 1; m_por = 1; end
      else if (m_mode == 1) begin
        if (m_cnt == 0) m_mode = pick(m_ctrl, m_pend, m_por); else m_cnt--;
      end else if (sw) begin m_mode = 1; m_cnt = POR - 1; m_ctrl = 1; m_pend = 0; end
      else begin
        t = pick(m_ctrl, m_pend, m_por);
        if (w && a == 7) m_ctrl = d & 'h73;
        if (rr && a == 4) begin m_pend = 0; m_por = 0; end
        m_pend = m_pend | e;
        m_mode = t;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wreg(int d);
    step(1, 0, 0, 1, 0, 7, d, 0); idle(2);
  endtask
  task automatic rreg(int a);
    step(1, 0, 0, 0, 1, a, 0, 0);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    tag = "R2";
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 7, 'h02, 0);
    step(1, 0, 0, 0, 1, 7, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 'h5);
    idle(POR - 3);
    tag = "R4"; idle(1); rreg(7);
    tag = "R12"; wreg('h00); idle(2);
    tag = "R11"; rreg(4); idle(2);
    tag = "R5"; wreg('h00);
    tag = "R6"; wreg('h40);
    tag = "R7"; wreg('h20); wreg('h10); wreg('h30); wreg('h70);
    tag = "R8"; wreg('h01); wreg('h41); wreg('h31);
    tag = "R9"; wreg('h02); wreg('h72);
    tag = "R10"; wreg('h03); wreg('h61); wreg('h50); wreg('h7F);
    tag = "R3"; wreg('hFF); rreg(7); rreg(3); wreg('h8C); rreg(7);
    tag = "R12"; wreg('h40);
    step(1, 0, 0, 0, 0, 0, 0, 'h2); idle(2);
    tag = "R11"; step(1, 0, 0, 0, 1, 4, 0, 'h4); rreg(4); idle(2);
    tag = "R12"; step(1, 0, 0, 0, 0, 0, 0, 'h8); idle(1); wreg('h20); rreg(4); idle(2);
    tag = "R13"; step(1, 0, 0, 0, 0, 0, 0, 'h1);
    step(1, 0, 1, 0, 0, 0, 0, 0); idle(POR + 1); rreg(7); wreg('h00); idle(1);
    tag = "R1";
    step(1, 0, 0, 0, 0, 0, 0, 'h3);
    step(1, 1, 0, 1, 0, 7, 'h02, 0);
    step(1, 1, 0, 0, 1, 7, 0, 0);
    step(1, 1, 0, 0, 1, 4, 0, 'hF);
    tag = "R2"; step(1, 0, 0, 1, 0, 7, 'h00, 0); idle(POR + 1);
    tag = "R12"; wreg('h00); rreg(4); idle(2);
    tag = "R5"; rreg(7); idle(1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule